// File: doc/BRIEF.md
# Speculative Register State with Held-Store Queue

This block keeps the architectural state of a core that executes reordered, translated code in blocks. Each register exists twice. Execution reads and writes the working copy. The checkpoint copy holds the state as of the last block boundary. Stores do not go to memory when they execute. They wait in a small queue. Loads look into that queue first and take any pending bytes from it, so a load always sees the effect of earlier stores in the same block.

At a block boundary, `commit` snapshots every working register into its checkpoint in one cycle. It also hands the queued stores to a valid/ready memory write port, which takes them one at a time and oldest first. When a fault occurs, `rollback` copies the checkpoint back into the working registers in one cycle and throws away stores that have not been committed. The core can then re-run the block from a precise point.

Register writes carry a byte mask, so a narrow update leaves the other bytes unchanged. A store that cannot be taken raises `st_stall` and is dropped. The core must hold it and present it again.

Top module: `ckpt_state_unit`

## Requirements
- R1: After reset, every working and checkpoint register reads zero, the store queue is empty, `st_stall`, `commit_busy` and `mw_valid` are low, and a load returns `mem_rd_data` unchanged.
- R2: A register write updates only the bytes of the working copy whose `wr_be` bit is set (bit i covers data bits 8i+7..8i). `rd_data` shows the working copy of `rd_addr` in the same cycle, without a clock edge.
- R3: An accepted store is never presented on the memory write port before a `commit` that is not overridden has been accepted. `mw_valid` stays low while `commit_busy` is low.
- R4: `ld_data` is built byte by byte. For each byte lane, it takes the youngest pending store with the same word address and that lane's enable set. Lanes with no such store come from `mem_rd_data`.
- R5: The queue holds SB_DEPTH entries. `st_stall` is high when the queue is full, while a drain is in progress, or in a cycle where `commit` or `rollback` is high. A store presented while `st_stall` is high is discarded.
- R6: An accepted commit copies every working register to its checkpoint. A register write in the same cycle lands in the working copy only, and the checkpoint receives the value from before the write.
- R7: After a commit with pending stores, `commit_busy` rises on the next cycle. Stores leave in program order, one per cycle in which `mw_valid` and `mw_ready` are both high. Address, data and mask stay stable while `mw_ready` is low. `commit_busy` falls after the last handshake.
- R8: A commit presented while `commit_busy` is high is ignored and does not change the checkpoint.
- R9: `rollback` loads every working register from its checkpoint in one cycle and overrides a register write in the same cycle. When no drain is in progress, it empties the queue and no entry reaches memory.
- R10: When `commit` and `rollback` are both high, only the rollback takes effect and no drain starts.
- R11: A rollback during a drain restores the registers but keeps the committed stores, which go on draining.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr | input | $clog2(NREGS) | Register read index |
| rd_data | output | XLEN | Working copy of the addressed register |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | $clog2(NREGS) | Register write index |
| wr_data | input | XLEN | Register write value |
| wr_be | input | XLEN/8 | Per-byte write mask |
| st_valid | input | 1 | Store presented |
| st_addr | input | AW | Store word address |
| st_data | input | XLEN | Store data |
| st_be | input | XLEN/8 | Store byte mask |
| st_stall | output | 1 | Store cannot be taken this cycle |
| ld_addr | input | AW | Load word address, also the memory read address |
| mem_rd_data | input | XLEN | Memory word at `ld_addr` |
| ld_data | output | XLEN | Load result after merging with pending stores |
| commit | input | 1 | Block boundary: snapshot and release stores |
| rollback | input | 1 | Fault: restore registers and drop uncommitted stores |
| commit_busy | output | 1 | Committed stores still draining |
| mw_valid | output | 1 | Memory write request |
| mw_ready | input | 1 | Memory accepts the request |
| mw_addr | output | AW | Memory write word address |
| mw_data | output | XLEN | Memory write data |
| mw_be | output | XLEN/8 | Memory write byte mask |

## Verification
The bench builds the block with NREGS=8, XLEN=32, AW=8 and SB_DEPTH=4. The four-entry queue fills after a handful of stores, so the full-queue stall and pointer wraparound come up constantly under random traffic. Random stores and loads are confined to 16 word addresses, which makes several pending stores to the same word with overlapping masks common. That exercises youngest-wins forwarding and partial-lane merging. `mw_ready` is random, so drains stretch across many cycles and commits and rollbacks often land inside them.

// File: rtl/ckpt_pkg.sv
package ckpt_pkg;
  localparam int unsigned LANE_W = 8;

  typedef enum logic {
    SB_FILL  = 1'b0,
    SB_DRAIN = 1'b1
  } sb_mode_t;
endpackage

// File: rtl/ckpt_regbank.sv
module ckpt_regbank #(
  parameter int unsigned NREGS = 16,
  parameter int unsigned XLEN  = 32,
  localparam int unsigned RAW  = $clog2(NREGS),
  localparam int unsigned NB   = XLEN / ckpt_pkg::LANE_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [RAW-1:0]  rd_addr,
  output logic [XLEN-1:0] rd_data,
  input  logic            wr_en,
  input  logic [RAW-1:0]  wr_addr,
  input  logic [XLEN-1:0] wr_data,
  input  logic [NB-1:0]   wr_be,
  input  logic            snap,
  input  logic            restore
);
  import ckpt_pkg::*;

  logic [XLEN-1:0] work [NREGS];
  logic [XLEN-1:0] ckpt [NREGS];

  assign rd_data = work[rd_addr];

  // Working copies: a restore overrides any write in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) work[i] <= '0;
    end else if (restore) begin
      for (int i = 0; i < NREGS; i++) work[i] <= ckpt[i];
    end else if (wr_en) begin
      for (int b = 0; b < NB; b++)
        if (wr_be[b])
          work[wr_addr][b*LANE_W +: LANE_W] <= wr_data[b*LANE_W +: LANE_W];
    end
  end

  // Checkpoint copies take the pre-edge working values.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) ckpt[i] <= '0;
    end else if (snap) begin
      for (int i = 0; i < NREGS; i++) ckpt[i] <= work[i];
    end
  end
endmodule

// File: rtl/ckpt_stbuf.sv
module ckpt_stbuf #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 32,
  parameter int unsigned XLEN  = 32,
  localparam int unsigned NB   = XLEN / ckpt_pkg::LANE_W,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = PW + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic [AW-1:0]   push_addr,
  input  logic [XLEN-1:0] push_data,
  input  logic [NB-1:0]   push_be,
  input  logic            release_q,
  input  logic            discard,
  output logic            full,
  output logic            draining,
  input  logic [AW-1:0]   ld_addr,
  input  logic [XLEN-1:0] mem_rd_data,
  output logic [XLEN-1:0] ld_data,
  output logic            mw_valid,
  input  logic            mw_ready,
  output logic [AW-1:0]   mw_addr,
  output logic [XLEN-1:0] mw_data,
  output logic [NB-1:0]   mw_be
);
  import ckpt_pkg::*;

  // DEPTH must be a power of two of at least 2 so pointers wrap naturally.
  logic [AW-1:0]   e_addr [DEPTH];
  logic [XLEN-1:0] e_data [DEPTH];
  logic [NB-1:0]   e_be   [DEPTH];

  logic [PW-1:0] head, tail;
  logic [CW-1:0] cnt;
  sb_mode_t      mode;
  logic          pop;

  assign full     = (cnt == CW'(DEPTH));
  assign draining = (mode == SB_DRAIN);
  assign pop      = draining && mw_ready;

  assign mw_valid = draining;
  assign mw_addr  = e_addr[head];
  assign mw_data  = e_data[head];
  assign mw_be    = e_be[head];

  // Entry storage: write-only at the tail, no reset needed.
  always_ff @(posedge clk) begin
    if (push) begin
      e_addr[tail] <= push_addr;
      e_data[tail] <= push_data;
      e_be[tail]   <= push_be;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
      mode <= SB_FILL;
    end else begin
      case (mode)
        SB_FILL: begin
          if (discard) begin
            head <= tail;
            cnt  <= '0;
          end else begin
            if (push) begin
              tail <= tail + 1'b1;
              cnt  <= cnt + 1'b1;
            end
            if (release_q && cnt != '0) mode <= SB_DRAIN;
          end
        end
        SB_DRAIN: begin
          if (pop) begin
            head <= head + 1'b1;
            cnt  <= cnt - 1'b1;
            if (cnt == CW'(1)) mode <= SB_FILL;
          end
        end
        default: mode <= SB_FILL;
      endcase
    end
  end

  // Forwarding: walk oldest to youngest so younger lanes overwrite older.
  always_comb begin
    logic [PW-1:0] idx;
    ld_data = mem_rd_data;
    idx     = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head + PW'(k);
      if ((CW'(k) < cnt) && (e_addr[idx] == ld_addr)) begin
        for (int b = 0; b < NB; b++)
          if (e_be[idx][b])
            ld_data[b*LANE_W +: LANE_W] = e_data[idx][b*LANE_W +: LANE_W];
      end
    end
  end
endmodule

// File: rtl/ckpt_state_unit.sv
module ckpt_state_unit #(
  parameter int unsigned NREGS    = 16,
  parameter int unsigned XLEN     = 32,
  parameter int unsigned AW       = 32,
  parameter int unsigned SB_DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [$clog2(NREGS)-1:0] rd_addr,
  output logic [XLEN-1:0]          rd_data,
  input  logic                     wr_en,
  input  logic [$clog2(NREGS)-1:0] wr_addr,
  input  logic [XLEN-1:0]          wr_data,
  input  logic [XLEN/8-1:0]        wr_be,
  input  logic                     st_valid,
  input  logic [AW-1:0]            st_addr,
  input  logic [XLEN-1:0]          st_data,
  input  logic [XLEN/8-1:0]        st_be,
  output logic                     st_stall,
  input  logic [AW-1:0]            ld_addr,
  input  logic [XLEN-1:0]          mem_rd_data,
  output logic [XLEN-1:0]          ld_data,
  input  logic                     commit,
  input  logic                     rollback,
  output logic                     commit_busy,
  output logic                     mw_valid,
  input  logic                     mw_ready,
  output logic [AW-1:0]            mw_addr,
  output logic [XLEN-1:0]          mw_data,
  output logic [XLEN/8-1:0]        mw_be
);
  logic commit_ok, sb_push, sb_full, sb_busy;

  // Rollback beats commit; a commit during a drain is dropped.
  assign commit_ok   = commit && !rollback && !sb_busy;
  assign st_stall    = sb_full || sb_busy || commit || rollback;
  assign sb_push     = st_valid && !st_stall;
  assign commit_busy = sb_busy;

  ckpt_regbank #(.NREGS(NREGS), .XLEN(XLEN)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .wr_be   (wr_be),
    .snap    (commit_ok),
    .restore (rollback)
  );

  ckpt_stbuf #(.DEPTH(SB_DEPTH), .AW(AW), .XLEN(XLEN)) u_sb (
    .clk         (clk),
    .rst         (rst),
    .push        (sb_push),
    .push_addr   (st_addr),
    .push_data   (st_data),
    .push_be     (st_be),
    .release_q   (commit_ok),
    .discard     (rollback),
    .full        (sb_full),
    .draining    (sb_busy),
    .ld_addr     (ld_addr),
    .mem_rd_data (mem_rd_data),
    .ld_data     (ld_data),
    .mw_valid    (mw_valid),
    .mw_ready    (mw_ready),
    .mw_addr     (mw_addr),
    .mw_data     (mw_data),
    .mw_be       (mw_be)
  );
endmodule

// File: rtl/ckpt_state_chk.sv
module ckpt_state_chk #(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned AW       = 32,
  parameter int unsigned SB_DEPTH = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              st_valid,
  input logic              st_stall,
  input logic              commit,
  input logic              rollback,
  input logic              commit_busy,
  input logic              mw_valid,
  input logic              mw_ready,
  input logic [AW-1:0]     mw_addr,
  input logic [XLEN-1:0]   mw_data,
  input logic [XLEN/8-1:0] mw_be
);
  logic [15:0] occ;

  // Entries held, tracked from the port handshakes alone.
  always_ff @(posedge clk) begin
    if (rst) occ <= '0;
    else if (rollback && !commit_busy) occ <= '0;
    else occ <= occ + 16'(st_valid && !st_stall) - 16'(mw_valid && mw_ready);
  end

  // R5
  sb_occupancy_chk: assert property (@(posedge clk) disable iff (rst)
    occ <= 16'(SB_DEPTH));

  // R3
  no_early_write_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mw_valid) |-> $past(commit && !rollback));

  // R7
  drain_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mw_valid && !mw_ready |=> mw_valid && $stable(mw_addr) && $stable(mw_data) && $stable(mw_be));

  // R9
  rollback_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    rollback && !commit_busy |=> !mw_valid);

  // R10
  rollback_wins_chk: assert property (@(posedge clk) disable iff (rst)
    commit && rollback && !commit_busy |=> !commit_busy);

  // R11
  drain_survives_chk: assert property (@(posedge clk) disable iff (rst)
    rollback && commit_busy && !mw_ready |=> mw_valid);
endmodule

bind ckpt_state_unit ckpt_state_chk #(.XLEN(XLEN), .AW(AW), .SB_DEPTH(SB_DEPTH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .st_valid    (st_valid),
  .st_stall    (st_stall),
  .commit      (commit),
  .rollback    (rollback),
  .commit_busy (commit_busy),
  .mw_valid    (mw_valid),
  .mw_ready    (mw_ready),
  .mw_addr     (mw_addr),
  .mw_data     (mw_data),
  .mw_be       (mw_be)
);

// File: tb/test_ckpt_state_unit.sv
`timescale 1ns/1ps
module test_ckpt_state_unit;
  localparam int NR = 8;
  localparam int XL = 32;
  localparam int AW = 8;
  localparam int SD = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [2:0]    rd_addr = '0, wr_addr = '0;
  logic [31:0]   rd_data, wr_data = '0, st_data = '0, ld_data, mem_rd_data, mw_data;
  logic [3:0]    wr_be = '0, st_be = '0, mw_be;
  logic          wr_en = 0, st_valid = 0, st_stall, commit = 0, rollback = 0;
  logic          commit_busy, mw_valid, mw_ready = 1;
  logic [AW-1:0] st_addr = '0, ld_addr = '0, mw_addr;

  logic [31:0] mem [0:255];
  assign mem_rd_data = mem[ld_addr];

  ckpt_state_unit #(.NREGS(NR), .XLEN(XL), .AW(AW), .SB_DEPTH(SD)) i_ckpt_state_unit (
    .clk(clk), .rst(rst), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
    .st_stall(st_stall), .ld_addr(ld_addr), .mem_rd_data(mem_rd_data), .ld_data(ld_data),
    .commit(commit), .rollback(rollback), .commit_busy(commit_busy),
    .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr), .mw_data(mw_data), .mw_be(mw_be)
  );

  // Reference model state
  logic [31:0]   m_work [0:NR-1];
  logic [31:0]   m_ckpt [0:NR-1];
  logic [AW-1:0] qa [0:SD-1];
  logic [31:0]   qd [0:SD-1];
  logic [3:0]    qb [0:SD-1];
  int            m_cnt;
  bit            m_busy;

  int  n_chk = 0, n_fail = 0;
  bit  done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_load(input logic [AW-1:0] a);
    logic [31:0] r = mem[a];
    for (int k = 0; k < m_cnt; k++)
      if (qa[k] == a)
        for (int b = 0; b < 4; b++)
          if (qb[k][b]) r[b*8 +: 8] = qd[k][b*8 +: 8];
    return r;
  endfunction

  task automatic set_idle();
    wr_en = 0; st_valid = 0; commit = 0; rollback = 0; mw_ready = 1;
  endtask

  // Called just after a falling edge with inputs set; checks, updates model, moves to next falling edge.
  task automatic cycle();
    bit stall_e, busy0, cok;
    #0.3;
    chk("R2 rd_data", rd_data, m_work[rd_addr]);
    chk("R4 ld_data", ld_data, exp_load(ld_addr));
    stall_e = (m_cnt == SD) || m_busy || commit || rollback;
    chk("R5 st_stall", 32'(st_stall), 32'(stall_e));
    chk("R7 commit_busy", 32'(commit_busy), 32'(m_busy));
    chk("R3 mw_valid", 32'(mw_valid), 32'(m_busy));
    if (m_busy) begin
      chk("R7 mw_addr", 32'(mw_addr), 32'(qa[0]));
      chk("R7 mw_data", mw_data, qd[0]);
      chk("R7 mw_be", 32'(mw_be), 32'(qb[0]));
    end
    busy0 = m_busy;
    cok   = commit && !rollback && !busy0;
    if (busy0 && mw_ready) begin
      for (int b = 0; b < 4; b++)
        if (qb[0][b]) mem[qa[0]][b*8 +: 8] = qd[0][b*8 +: 8];
      for (int k = 0; k < SD - 1; k++) begin
        qa[k] = qa[k+1]; qd[k] = qd[k+1]; qb[k] = qb[k+1];
      end
      m_cnt--;
      if (m_cnt == 0) m_busy = 0;
    end
    if (rollback) begin
      for (int i = 0; i < NR; i++) m_work[i] = m_ckpt[i];
      if (!busy0) m_cnt = 0;
    end else begin
      if (cok) begin
        for (int i = 0; i < NR; i++) m_ckpt[i] = m_work[i];
        if (m_cnt != 0) m_busy = 1;
      end
      if (wr_en)
        for (int b = 0; b < 4; b++)
          if (wr_be[b]) m_work[wr_addr][b*8 +: 8] = wr_data[b*8 +: 8];
    end
    if (st_valid && !stall_e) begin
      qa[m_cnt] = st_addr; qd[m_cnt] = st_data; qb[m_cnt] = st_be;
      m_cnt++;
    end
    @(negedge clk);
  endtask

  task automatic do_write(input logic [2:0] r, input logic [31:0] d, input logic [3:0] be);
    set_idle(); wr_en = 1; wr_addr = r; wr_data = d; wr_be = be; cycle();
  endtask

  task automatic do_store(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be);
    set_idle(); st_valid = 1; st_addr = a; st_data = d; st_be = be; cycle();
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R7 watchdog act=running exp=finished");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[5] = 32'hF0F1F2F3;
    for (int i = 0; i < NR; i++) begin m_work[i] = '0; m_ckpt[i] = '0; end
    m_cnt = 0; m_busy = 0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1: reset state
    #0.1;
    chk("R1 st_stall", 32'(st_stall), 0);
    chk("R1 commit_busy", 32'(commit_busy), 0);
    chk("R1 mw_valid", 32'(mw_valid), 0);
    for (int r = 0; r < NR; r++) begin
      set_idle(); rd_addr = 3'(r); cycle();
    end
    set_idle(); rollback = 1; cycle();
    set_idle();
    for (int r = 0; r < NR; r++) begin
      rd_addr = 3'(r); #0.1; chk("R1 checkpoint zero", rd_data, 0); cycle();
    end

    // R2: partial write keeps other lanes
    do_write(3, 32'h11223344, 4'b1111);
    do_write(3, 32'hAABBCCDD, 4'b0001);
    set_idle(); rd_addr = 3; #0.1;
    chk("R2 partial write", rd_data, 32'h112233DD);
    cycle();

    // R4: youngest wins per lane, rest from memory
    do_store(5, 32'h00001111, 4'b0011);
    do_store(5, 32'h00002200, 4'b0010);
    set_idle(); ld_addr = 5; #0.1;
    chk("R4 merged load", ld_data, 32'hF0F12211);
    cycle();

    // R9: rollback restores registers and drops stores
    set_idle(); rollback = 1; wr_en = 1; wr_addr = 3; wr_data = 32'h99999999; wr_be = 4'hF; cycle();
    set_idle(); rd_addr = 3; ld_addr = 5; #0.1;
    chk("R9 reg restored", rd_data, 32'h0);
    chk("R9 stores dropped", ld_data, 32'hF0F1F2F3);
    chk("R9 no write", 32'(mw_valid), 0);
    cycle();

    // R6: same-cycle write goes to working only
    do_write(4, 32'h0000000A, 4'hF);
    set_idle(); commit = 1; wr_en = 1; wr_addr = 4; wr_data = 32'hB; wr_be = 4'hF; cycle();
    set_idle(); rd_addr = 4; #0.1; chk("R6 working updated", rd_data, 32'hB); cycle();
    set_idle(); rollback = 1; cycle();
    set_idle(); rd_addr = 4; #0.1; chk("R6 checkpoint pre-write", rd_data, 32'hA); cycle();

    // R10: rollback beats commit
    do_write(4, 32'h0000000C, 4'hF);
    do_store(9, 32'h12345678, 4'hF);
    set_idle(); commit = 1; rollback = 1; cycle();
    set_idle(); rd_addr = 4; ld_addr = 9; #0.1;
    chk("R10 no drain", 32'(commit_busy), 0);
    chk("R10 reg restored", rd_data, 32'hA);
    chk("R10 store dropped", ld_data, 32'h0);
    cycle();

    // R5: full queue stalls and drops; R7 drain with back-pressure
    do_write(1, 32'h66, 4'hF);
    for (int k = 0; k < SD; k++) do_store(AW'(20 + k), 32'h100 + 32'(k), 4'hF);
    set_idle(); st_valid = 1; st_addr = 24; st_data = 32'hDEAD; st_be = 4'hF; #0.1;
    chk("R5 full stall", 32'(st_stall), 1);
    cycle();
    set_idle(); mw_ready = 0; commit = 1; cycle();
    for (int k = 0; k < 3; k++) begin
      set_idle(); mw_ready = 0; #0.1;
      chk("R7 held addr", 32'(mw_addr), 32'd20);
      cycle();
    end
    // R8: commit during drain ignored
    set_idle(); mw_ready = 0; commit = 1; wr_en = 1; wr_addr = 1; wr_data = 32'h77; wr_be = 4'hF; cycle();
    // R11: rollback during drain keeps stores
    set_idle(); mw_ready = 0; rollback = 1; cycle();
    set_idle(); mw_ready = 0; rd_addr = 1; #0.1;
    chk("R8 checkpoint unchanged", rd_data, 32'h66);
    chk("R11 drain continues", 32'(mw_valid), 1);
    cycle();
    for (int k = 0; k < SD; k++) begin set_idle(); cycle(); end
    set_idle(); ld_addr = 23; #0.1; chk("R7 drained last", ld_data, 32'h103); cycle();
    set_idle(); ld_addr = 24; #0.1; chk("R5 stalled store dropped", ld_data, 32'h0); cycle();

    // Random traffic
    for (int n = 0; n < 4000; n++) begin
      int p;
      set_idle();
      rd_addr = 3'($urandom % NR);
      ld_addr = AW'($urandom % 16);
      wr_en   = ($urandom % 3) == 0;
      wr_addr = 3'($urandom % NR);
      wr_data = $urandom;
      wr_be   = 4'($urandom);
      st_valid = ($urandom % 2) == 0;
      st_addr  = AW'($urandom % 16);
      st_data  = $urandom;
      st_be    = 4'($urandom);
      mw_ready = ($urandom % 2) == 0;
      p = int'($urandom % 100);
      commit   = p < 12;
      rollback = (p >= 8 && p < 11) || p == 99;
      cycle();
    end

    done = 1;
    finish_run();
  end
endmodule